// File: doc/BRIEF.md
# Shared Video Register Write Arbiter

This block sits between a CPU bus, a display coprocessor and a video chip. The video chip's register file can only be reached while the video chip grants bus access. The coprocessor sends register writes through a valid/ready handshake. A write aimed at the video chip waits until the grant input is high. Once it goes out, it owns the local bus for that cycle and beats any CPU access to the shared I/O window. A coprocessor write aimed at its own register file is accepted at once, whatever the grant is doing.

The CPU runs on without losing cycles whenever it stays outside the 1 KiB I/O window at 0xD000. The stack page is one such region.

Inside the window there are two cases when the local bus is taken:
- **CPU read:** the block pulls the ready line low.
- **CPU write:** a processor of this kind cannot be stopped on a write, so the block latches the write into a single-entry buffer. It then replays the buffered write in the first cycle in which the coprocessor leaves the bus free. A CPU read waiting in the window is held for that replay cycle too.

The buffer keeps only the newest captured write. In a read-modify-write pair, only the second store reaches the video chip.

Top module: `vreg_wr_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, loc_cs and own_we are 0. The replay buffer is empty, so a CPU access outside the window sees cpu_rdy = 1.
- R2: While cop_valid = 1, cop_to_vid = 1 and vid_grant = 0, cop_ready is 0 and no coprocessor write appears on the local bus.
- R3: A coprocessor request with cop_to_vid = 0 gets cop_ready = 1 in the same cycle, independent of vid_grant. The next cycle shows own_we = 1 with that address and data. Such a request never drives loc_cs.
- R4: A coprocessor request with cop_to_vid = 1 and vid_grant = 1 gets cop_ready = 1. The next cycle shows loc_cs = 1, loc_wr = 1, loc_addr = cop_addr and loc_wdata = cop_data.
- R5: A CPU address outside 0xD000–0xD3FF, stack page 0x0100–0x01FF included, keeps cpu_rdy = 1, is never captured and never appears on the local bus.
- R6: A CPU access inside the window, with no coprocessor write firing and the buffer empty, appears on the local bus the next cycle with loc_addr = cpu_addr[9:0] and loc_wr = cpu_wr. On reads loc_wdata is 0. cpu_rdy stays 1.
- R7: A CPU read inside the window drives cpu_rdy = 0 in any cycle in which a coprocessor video write fires or the buffer holds a write.
- R8: A CPU write inside the window that coincides with a coprocessor video write keeps cpu_rdy = 1 and is captured into the buffer. The coprocessor write reaches the local bus unchanged.
- R9: In the first cycle with the buffer full and no coprocessor video write firing, the buffered write is replayed. The next cycle shows loc_cs = 1, loc_wr = 1 and the buffered address and data. The buffer then empties unless a new window write is captured in that same cycle.
- R10: Two captured CPU writes in a row leave only the second in the buffer; only that one is replayed.
- R11: While coprocessor video writes keep firing every cycle, the buffered CPU write stays pending and a CPU read in the window stays halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address of the current bus cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | 1 = CPU write cycle, 0 = CPU read cycle |
| cpu_rdy | output | 1 | CPU ready; 0 halts a CPU read |
| cop_valid | input | 1 | Coprocessor write request valid |
| cop_to_vid | input | 1 | 1 = target is a video chip register, 0 = coprocessor's own register |
| cop_addr | input | 10 | Coprocessor register address |
| cop_data | input | 8 | Coprocessor write data |
| cop_ready | output | 1 | Coprocessor request accepted this cycle |
| vid_grant | input | 1 | Video chip bus grant (high = registers reachable) |
| loc_cs | output | 1 | Local bus chip select |
| loc_wr | output | 1 | Local bus write strobe (0 = read) |
| loc_addr | output | 10 | Local bus register address |
| loc_wdata | output | 8 | Local bus write data |
| own_we | output | 1 | Write enable into the coprocessor's own registers |
| own_addr | output | 10 | Own-register address |
| own_wdata | output | 8 | Own-register write data |

## Verification
The replay buffer's valid flag and its captured address/data are the only hidden state. A wrong flag shows at the ports within one cycle:
- **Stuck set:** a CPU read in the window is stalled with no coprocessor activity.
- **Dropped or never set:** the cycle after the coprocessor stops firing shows an idle or direct CPU bus cycle instead of the replayed write.

A wrong captured value shows as the wrong address or data on the local bus in the replay cycle, one cycle after the collision ends. Long stimulus sweeps that mix grant gaps, back-to-back coprocessor writes and window, stack and ordinary CPU cycles drive every such state, including a new capture landing in a replay cycle.

// File: rtl/vwa_pkg.sv
package vwa_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_COP    = 2'd1,
    SLOT_REPLAY = 2'd2,
    SLOT_CPU    = 2'd3
  } slot_e;
endpackage

// File: rtl/vwa_win_decode.sv
module vwa_win_decode #(
  parameter int                CPU_AW   = 16,
  parameter int                LOC_AW   = 10,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'hD000
) (
  input  logic [CPU_AW-1:0] addr,
  output logic              in_win,
  output logic [LOC_AW-1:0] offset
);
  localparam int TAG_W = CPU_AW - LOC_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[CPU_AW-1:LOC_AW];

  always_comb begin
    in_win = (addr[CPU_AW-1:LOC_AW] == WIN_TAG);
    offset = addr[LOC_AW-1:0];
  end
endmodule

// File: rtl/vwa_slot_arb.sv
module vwa_slot_arb
  import vwa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cop_valid,
  input  logic  cop_to_vid,
  input  logic  vid_grant,
  input  logic  cpu_in_win,
  input  logic  cpu_wr,
  input  logic  buf_valid,
  output slot_e slot,
  output logic  cop_ready,
  output logic  own_fire,
  output logic  cpu_rdy,
  output logic  capture
);
  logic cop_fire;
  logic bus_taken;

  always_comb begin
    cop_fire  = cop_valid & cop_to_vid & vid_grant;
    own_fire  = cop_valid & ~cop_to_vid;
    cop_ready = cop_fire | own_fire;
    bus_taken = cop_fire | buf_valid;
    capture   = cpu_in_win & cpu_wr & bus_taken;
    cpu_rdy   = ~(cpu_in_win & ~cpu_wr & bus_taken);
    if (cop_fire)        slot = SLOT_COP;
    else if (buf_valid)  slot = SLOT_REPLAY;
    else if (cpu_in_win) slot = SLOT_CPU;
    else                 slot = SLOT_IDLE;
  end

  AST_COP_WAITS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && cop_to_vid && !vid_grant) |-> !cop_ready); // R2
  AST_OWN_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && !cop_to_vid) |-> cop_ready); // R3
  AST_WRITE_NEVER_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> cpu_rdy); // R8
  AST_REPLAY_BEFORE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !(cop_valid && cop_to_vid && vid_grant)) |-> (slot == SLOT_REPLAY)); // R9
endmodule

// File: rtl/vwa_replay_buf.sv
module vwa_replay_buf #(
  parameter int LOC_AW = 10,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [LOC_AW-1:0] cap_addr,
  input  logic [DW-1:0]     cap_data,
  input  logic              drain,
  output logic              valid,
  output logic [LOC_AW-1:0] addr,
  output logic [DW-1:0]     data
);
  logic              valid_d;
  logic              load_en;
  logic [LOC_AW-1:0] addr_d;
  logic [DW-1:0]     data_d;

  always_comb begin
    load_en = capture;
    valid_d = valid;
    addr_d  = addr;
    data_d  = data;
    if (load_en) begin
      valid_d = 1'b1;
      addr_d  = cap_addr;
      data_d  = cap_data;
    end else if (drain) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else begin
      valid <= valid_d;
      if (load_en) begin
        addr <= addr_d;
        data <= data_d;
      end
    end
  end

  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> valid); // R8
  AST_LAST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (addr == $past(cap_addr) && data == $past(cap_data))); // R10
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !capture) |=> !valid); // R9
endmodule

// File: rtl/vreg_wr_arbiter.sv
module vreg_wr_arbiter
  import vwa_pkg::*;
#(
  parameter int                CPU_AW   = 16,
  parameter int                LOC_AW   = 10,
  parameter int                DW       = 8,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'hD000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_wr,
  output logic              cpu_rdy,
  input  logic              cop_valid,
  input  logic              cop_to_vid,
  input  logic [LOC_AW-1:0] cop_addr,
  input  logic [DW-1:0]     cop_data,
  output logic              cop_ready,
  input  logic              vid_grant,
  output logic              loc_cs,
  output logic              loc_wr,
  output logic [LOC_AW-1:0] loc_addr,
  output logic [DW-1:0]     loc_wdata,
  output logic              own_we,
  output logic [LOC_AW-1:0] own_addr,
  output logic [DW-1:0]     own_wdata
);
  logic              in_win;
  logic [LOC_AW-1:0] win_off;
  slot_e             slot;
  logic              own_fire;
  logic              capture;
  logic              drain;
  logic              buf_valid;
  logic [LOC_AW-1:0] buf_addr;
  logic [DW-1:0]     buf_data;

  logic              loc_cs_d, loc_wr_d, own_we_d;
  logic [LOC_AW-1:0] loc_addr_d, own_addr_d;
  logic [DW-1:0]     loc_wdata_d, own_wdata_d;

  vwa_win_decode #(.CPU_AW(CPU_AW), .LOC_AW(LOC_AW), .WIN_BASE(WIN_BASE)) win_i (
    .addr   (cpu_addr),
    .in_win (in_win),
    .offset (win_off)
  );

  vwa_slot_arb arb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cop_valid  (cop_valid),
    .cop_to_vid (cop_to_vid),
    .vid_grant  (vid_grant),
    .cpu_in_win (in_win),
    .cpu_wr     (cpu_wr),
    .buf_valid  (buf_valid),
    .slot       (slot),
    .cop_ready  (cop_ready),
    .own_fire   (own_fire),
    .cpu_rdy    (cpu_rdy),
    .capture    (capture)
  );

  assign drain = (slot == SLOT_REPLAY);

  vwa_replay_buf #(.LOC_AW(LOC_AW), .DW(DW)) buf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .cap_addr (win_off),
    .cap_data (cpu_wdata),
    .drain    (drain),
    .valid    (buf_valid),
    .addr     (buf_addr),
    .data     (buf_data)
  );

  // Next-state of the local bus and own-register ports
  always_comb begin
    loc_cs_d    = 1'b0;
    loc_wr_d    = 1'b0;
    loc_addr_d  = '0;
    loc_wdata_d = '0;
    unique case (slot)
      SLOT_COP: begin
        loc_cs_d    = 1'b1;
        loc_wr_d    = 1'b1;
        loc_addr_d  = cop_addr;
        loc_wdata_d = cop_data;
      end
      SLOT_REPLAY: begin
        loc_cs_d    = 1'b1;
        loc_wr_d    = 1'b1;
        loc_addr_d  = buf_addr;
        loc_wdata_d = buf_data;
      end
      SLOT_CPU: begin
        loc_cs_d    = 1'b1;
        loc_wr_d    = cpu_wr;
        loc_addr_d  = win_off;
        loc_wdata_d = cpu_wr ? cpu_wdata : '0;
      end
      default: ;
    endcase
    own_we_d    = own_fire;
    own_addr_d  = own_fire ? cop_addr : '0;
    own_wdata_d = own_fire ? cop_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_cs    <= 1'b0;
      loc_wr    <= 1'b0;
      loc_addr  <= '0;
      loc_wdata <= '0;
      own_we    <= 1'b0;
      own_addr  <= '0;
      own_wdata <= '0;
    end else begin
      loc_cs    <= loc_cs_d;
      loc_wr    <= loc_wr_d;
      loc_addr  <= loc_addr_d;
      loc_wdata <= loc_wdata_d;
      own_we    <= own_we_d;
      own_addr  <= own_addr_d;
      own_wdata <= own_wdata_d;
    end
  end

  AST_COP_REACHES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && cop_to_vid && vid_grant) |=>
      (loc_cs && loc_wr && loc_addr == $past(cop_addr) && loc_wdata == $past(cop_data))); // R4
  AST_OUTSIDE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[CPU_AW-1:LOC_AW] != WIN_BASE[CPU_AW-1:LOC_AW]) |-> cpu_rdy); // R5
  AST_READ_HALT_ON_COP: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && cop_to_vid && vid_grant && !cpu_wr &&
     cpu_addr[CPU_AW-1:LOC_AW] == WIN_BASE[CPU_AW-1:LOC_AW]) |-> !cpu_rdy); // R7
  AST_NO_BUS_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && cop_to_vid && !vid_grant && !buf_valid && !in_win) |=> !loc_cs); // R2
  AST_OWN_WRITE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && !cop_to_vid) |=> (own_we && own_addr == $past(cop_addr))); // R3
endmodule

// File: tb/vreg_wr_arbiter_tb_top.sv
module vreg_wr_arbiter_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic        cpu_rdy;
  logic        cop_valid, cop_to_vid, vid_grant, cop_ready;
  logic [9:0]  cop_addr;
  logic [7:0]  cop_data;
  logic        loc_cs, loc_wr, own_we;
  logic [9:0]  loc_addr, own_addr;
  logic [7:0]  loc_wdata, own_wdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  bit       m_bv;
  bit [9:0] m_ba;
  bit [7:0] m_bd;
  bit       e_cs, e_wr, e_own;
  bit [9:0] e_addr, e_oaddr;
  bit [7:0] e_data, e_odata;

  vreg_wr_arbiter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rdy(cpu_rdy),
    .cop_valid(cop_valid), .cop_to_vid(cop_to_vid), .cop_addr(cop_addr),
    .cop_data(cop_data), .cop_ready(cop_ready), .vid_grant(vid_grant),
    .loc_cs(loc_cs), .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .own_we(own_we), .own_addr(own_addr), .own_wdata(own_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    string rq;
    rq = e_cs ? "R4/R6/R9 local" : "R2/R5 local idle";
    chk(loc_cs == e_cs, rq, loc_cs, e_cs);
    if (e_cs) begin
      chk({loc_wr, loc_addr, loc_wdata} == {e_wr, e_addr, e_data}, "R9 R10 local cycle",
          {loc_wr, loc_addr, loc_wdata}, {e_wr, e_addr, e_data});
    end
    chk({own_we, own_addr, own_wdata} == {e_own, e_oaddr, e_odata}, "R3 own write",
        {own_we, own_addr, own_wdata}, {e_own, e_oaddr, e_odata});
  endtask

  task automatic step(input bit cv, input bit cvid, input bit g, input bit [9:0] ca,
                      input bit [7:0] cd, input bit [15:0] pa, input bit [7:0] pd,
                      input bit pw);
    bit inw, fire, exp_rdy, exp_cr;
    @(negedge clk);
    check_regs();
    cop_valid = cv; cop_to_vid = cvid; vid_grant = g; cop_addr = ca; cop_data = cd;
    cpu_addr = pa; cpu_wdata = pd; cpu_wr = pw;
    #1;
    inw     = (pa[15:10] == 6'b110100);
    fire    = cv & cvid & g;
    exp_cr  = cv & (~cvid | g);
    exp_rdy = !(inw && !pw && (fire || m_bv));
    chk(cop_ready == exp_cr, (cv & cvid & !g) ? "R2 cop wait" : "R3 R4 cop accept",
        cop_ready, exp_cr);
    chk(cpu_rdy == exp_rdy, !inw ? "R5 outside window" : (pw ? "R8 write ready" : "R7 R11 read halt"),
        cpu_rdy, exp_rdy);
    // expected next local bus cycle
    if (fire) begin
      e_cs = 1; e_wr = 1; e_addr = ca; e_data = cd;
    end else if (m_bv) begin
      e_cs = 1; e_wr = 1; e_addr = m_ba; e_data = m_bd;
    end else if (inw) begin
      e_cs = 1; e_wr = pw; e_addr = pa[9:0]; e_data = pw ? pd : 8'h00;
    end else begin
      e_cs = 0; e_wr = 0; e_addr = 0; e_data = 0;
    end
    e_own   = cv & ~cvid;
    e_oaddr = e_own ? ca : 10'h0;
    e_odata = e_own ? cd : 8'h00;
    if (inw && pw && (fire || m_bv)) begin
      m_bv = 1; m_ba = pa[9:0]; m_bd = pd;
    end else if (!fire && m_bv) begin
      m_bv = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    rst_n = 0;
    cop_valid = 0; cop_to_vid = 0; vid_grant = 0; cop_addr = 0; cop_data = 0;
    cpu_addr = 16'h8000; cpu_wdata = 0; cpu_wr = 0;
    m_bv = 0; e_cs = 0; e_wr = 0; e_addr = 0; e_data = 0;
    e_own = 0; e_oaddr = 0; e_odata = 0;
    repeat (3) @(negedge clk);
    chk(loc_cs == 0 && own_we == 0, "R1 reset outputs", {loc_cs, own_we}, 0);
    chk(cpu_rdy == 1, "R1 reset ready", cpu_rdy, 1);
    rst_n = 1;

    // R1: first cycle after reset idle
    step(0, 0, 0, 0, 0, 16'h8000, 0, 0);
    // R2: video write waits while grant low, then goes out (R4)
    step(1, 1, 0, 10'h021, 8'h02, 16'h1234, 0, 0);
    step(1, 1, 0, 10'h021, 8'h02, 16'h1234, 0, 0);
    step(1, 1, 1, 10'h021, 8'h02, 16'h1234, 0, 0);
    // R3: own write with grant low
    step(1, 0, 0, 10'h3F0, 8'hA5, 16'h2000, 0, 0);
    // R5: stack write during a cop fire is not captured
    step(1, 1, 1, 10'h020, 8'h05, 16'h01FD, 8'h77, 1);
    // R8 R10: two captured writes (read-modify-write pair), R11 replay held
    step(1, 1, 1, 10'h020, 8'h06, 16'hD019, 8'h01, 1);
    step(1, 1, 1, 10'h021, 8'h07, 16'hD019, 8'h00, 1);
    step(1, 1, 1, 10'h022, 8'h08, 16'hD012, 8'h00, 0);
    // R9: replay of only the second write, read still halted this cycle
    step(0, 0, 0, 0, 0, 16'hD012, 8'h00, 0);
    // R6: read proceeds directly
    step(0, 0, 0, 0, 0, 16'hD012, 8'h00, 0);
    step(0, 0, 0, 0, 0, 16'hD3FF, 8'h3C, 1);

    // near-exhaustive sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      bit [1:0]  reg_sel;
      bit [15:0] pa;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      reg_sel = lfsr[4:3];
      case (reg_sel)
        2'd0: pa = 16'h8000 | {6'd0, lfsr[9:0]};
        2'd1: pa = 16'h0100 | {8'd0, lfsr[7:0]};
        default: pa = 16'hD000 | {6'd0, lfsr[15:6]};
      endcase
      step(lfsr[0] | lfsr[8], lfsr[1] | lfsr[11], lfsr[2] | lfsr[5], lfsr[12:3], lfsr[7:0] ^ 8'h5A,
           pa, lfsr[15:8], lfsr[6]);
    end
    @(negedge clk);
    check_regs();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule